// File: doc/BRIEF.md
# SRAM Bus Cycle Controller

The controller turns single requests from an internal valid/ready port into cycles on an external asynchronous 16-bit SRAM bus. Each request carries a byte address, write data, a write flag and two byte enables. The block runs one bus cycle for it, then pulses ready for one clock. For a read, the captured halfword is returned on that same clock. The bus clock is the block clock.

An access lasts one bus cycle, plus a programmed count of internal wait cycles. Beyond that, an active-low external wait pin can stretch it, one cycle per low sample. That pin is sampled on the falling clock edge, and only when two conditions hold: the area is marked as SRAM and waiting is enabled.

Two byte-lane schemes are selectable.
- **Address-bit-zero scheme:** the low address bit and separate high and low write strobes are used.
- **Byte-select scheme:** the low address pin and the high strobe act as the memory's lane selects, and the low strobe acts as a common write enable. Here an endian bit swaps which lane each select pin addresses.

Write data is driven with an output enable for the whole write.

Top module: `sram_bus_ctrl`

## Requirements
- R1: A request seen with req_valid_i high while the block is idle starts an access on the next clock. In every cycle of the access, bus_ce_no is low and bus_addr_o equals req_addr_i[23:1]. A read keeps bus_rd_no low. With zero wait cycles the access lasts exactly one bus cycle. Read data is taken from bus_dq_i at the end of the last cycle.
- R2: With cfg_int_wait_i = N (0 to 7), the access is exactly N cycles longer than the one-cycle minimum whenever external waiting is not in effect.
- R3: When external waiting is in effect, bus_ext_wait_ni is first sampled on the falling edge of cycle N+1, and then on each following cycle. Each low sample adds one cycle, and the first high sample ends the access in that cycle. Low levels during cycles 1 to N have no effect.
- R4: External waiting is in effect only when cfg_is_sram_i = 1 and cfg_wait_en_i = 1. With any other setting the access lasts N+1 cycles, whatever the level of bus_ext_wait_ni.
- R5: With cfg_bsl_mode_i = 0, the pins behave as follows whatever cfg_big_endian_i is. bus_a0_o carries req_addr_i[0]. bus_wrh_no is low during a write with req_be_i[1] = 1. bus_wrl_no is low during a write with req_be_i[0] = 1. bus_rd_no is low during a read and high during a write.
- R6: With cfg_bsl_mode_i = 1 and cfg_big_endian_i = 0, the select pins are active low and follow the byte enables during both reads and writes. bus_a0_o selects the lane of req_be_i[0], and bus_wrh_no selects the lane of req_be_i[1]. bus_wrl_no is a common write enable, low for writes. bus_rd_no is the output enable, low for reads.
- R7: With cfg_bsl_mode_i = 1 and cfg_big_endian_i = 1, the two lanes are swapped relative to R6. bus_a0_o follows req_be_i[1], and bus_wrh_no follows req_be_i[0]. bus_wrl_no and bus_rd_no behave as in R6.
- R8: Chip enable, address and every strobe keep their values throughout an access. Between two accesses there is at least one clock with bus_ce_no, bus_rd_no, bus_wrh_no and bus_wrl_no all high.
- R9: bus_dq_oe_o is high with bus_dq_o equal to req_wdata_i in every cycle of a write. It is low at all other times.
- R10: req_ready_o is high for exactly one clock, the clock right after the last bus cycle. For a read, rsp_rdata_o holds the captured halfword on that clock.
- R11: After reset, bus_ce_no, bus_rd_no, bus_wrh_no and bus_wrl_no are high, and req_ready_o and bus_dq_oe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_is_sram_i | input | 1 | Area is configured as SRAM |
| cfg_wait_en_i | input | 1 | External wait enable |
| cfg_bsl_mode_i | input | 1 | 0 address-bit-zero lanes, 1 byte-select lanes |
| cfg_big_endian_i | input | 1 | Lane swap in byte-select scheme |
| cfg_int_wait_i | input | 3 | Internal wait cycle count |
| req_valid_i | input | 1 | Request present, held until ready |
| req_we_i | input | 1 | 1 write, 0 read |
| req_be_i | input | 2 | Byte enables, bit 1 high lane |
| req_addr_i | input | 24 | Byte address |
| req_wdata_i | input | 16 | Write data |
| req_ready_o | output | 1 | One-clock completion pulse |
| rsp_rdata_o | output | 16 | Read data |
| bus_addr_o | output | 23 | Halfword address |
| bus_a0_o | output | 1 | Address bit zero or low lane select |
| bus_ce_no | output | 1 | Chip enable, active low |
| bus_rd_no | output | 1 | Read strobe or output enable |
| bus_wrh_no | output | 1 | High write strobe or lane select |
| bus_wrl_no | output | 1 | Low write strobe or common write enable |
| bus_dq_o | output | 16 | Write data to the bus |
| bus_dq_oe_o | output | 1 | Data output enable |
| bus_dq_i | input | 16 | Read data from the bus |
| bus_ext_wait_ni | input | 1 | External wait, active low |

## Verification
The assertions check the following on every cycle:
- address and strobes hold steady within an access;
- an idle gap separates accesses;
- the ready pulse lasts a single clock and comes right after a bus cycle;
- the data output enable is confined to writes;
- no write strobe joins a read in the address-bit-zero scheme.

Some behaviour can only be shown by the bench's sweep over all wait counts, wait-pin windows, gating settings, lane schemes, endian settings and byte enables:
- exact access lengths;
- that the wait pin is ignored before cycle N+1 or when gated off;
- the expected level of each lane pin;
- the returned read data.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_RECOV = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic a0;
    logic wrh_n;
    logic wrl_n;
    logic rd_n;
  } strobe_t;
endpackage

// File: rtl/sram_wait_ctrl.sv
module sram_wait_ctrl #(
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] int_wait_i,
  input  logic              ext_en_i,
  input  logic              ext_wait_ni,
  input  logic              active_i,
  output logic              last_o
);
  logic [WAIT_W-1:0] cnt_q;
  logic              wait_low_q;

  // falling-edge sample of the external wait pin
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_low_q <= 1'b0;
    else         wait_low_q <= ~ext_wait_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (load_i)                     cnt_q <= int_wait_i;
    else if (active_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = active_i && (cnt_q == '0) && !(ext_en_i && wait_low_q);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_bus_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic last_i,
  output logic load_o,
  output logic active_o,
  output logic capture_o,
  output logic ready_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_ACT;
      ST_ACT:   if (last_i)      state_d = ST_RECOV;
      ST_RECOV:                  state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign load_o    = (state_q == ST_IDLE) && req_valid_i;
  assign active_o  = (state_q == ST_ACT);
  assign capture_o = (state_q == ST_ACT) && last_i;
  assign ready_o   = (state_q == ST_RECOV);
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map
  import sram_bus_pkg::*;
(
  input  logic       active_i,
  input  logic       we_i,
  input  logic [1:0] be_i,
  input  logic       addr0_i,
  input  logic       bsl_mode_i,
  input  logic       big_endian_i,
  output strobe_t    strb_o
);
  logic sel_lo, sel_hi;

  always_comb begin
    // lane addressed by each select pin in byte-select scheme
    sel_lo = big_endian_i ? be_i[1] : be_i[0];
    sel_hi = big_endian_i ? be_i[0] : be_i[1];
    strb_o.rd_n = ~(active_i & ~we_i);
    if (bsl_mode_i) begin
      strb_o.a0    = ~(active_i & sel_lo);
      strb_o.wrh_n = ~(active_i & sel_hi);
      strb_o.wrl_n = ~(active_i & we_i);
    end else begin
      strb_o.a0    = addr0_i;
      strb_o.wrh_n = ~(active_i & we_i & be_i[1]);
      strb_o.wrl_n = ~(active_i & we_i & be_i[0]);
    end
  end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_bus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 3,
  localparam int BE_W   = DATA_W / 8,
  localparam int BADR_W = ADDR_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_is_sram_i,
  input  logic              cfg_wait_en_i,
  input  logic              cfg_bsl_mode_i,
  input  logic              cfg_big_endian_i,
  input  logic [WAIT_W-1:0] cfg_int_wait_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [BADR_W-1:0] bus_addr_o,
  output logic              bus_a0_o,
  output logic              bus_ce_no,
  output logic              bus_rd_no,
  output logic              bus_wrh_no,
  output logic              bus_wrl_no,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_dq_oe_o,
  input  logic [DATA_W-1:0] bus_dq_i,
  input  logic              bus_ext_wait_ni
);
  logic              load, active, capture, last;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  strobe_t           strb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= req_addr_i;
      we_q    <= req_we_i;
      be_q    <= req_be_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (capture) rdata_q <= bus_dq_i;
  end

  sram_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .last_i      (last),
    .load_o      (load),
    .active_o    (active),
    .capture_o   (capture),
    .ready_o     (req_ready_o)
  );

  sram_wait_ctrl #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .int_wait_i  (cfg_int_wait_i),
    .ext_en_i    (cfg_is_sram_i & cfg_wait_en_i),
    .ext_wait_ni (bus_ext_wait_ni),
    .active_i    (active),
    .last_o      (last)
  );

  sram_lane_map u_lane (
    .active_i     (active),
    .we_i         (we_q),
    .be_i         (be_q),
    .addr0_i      (addr_q[0]),
    .bsl_mode_i   (cfg_bsl_mode_i),
    .big_endian_i (cfg_big_endian_i),
    .strb_o       (strb)
  );

  assign bus_addr_o  = addr_q[ADDR_W-1:1];
  assign bus_a0_o    = strb.a0;
  assign bus_wrh_no  = strb.wrh_n;
  assign bus_wrl_no  = strb.wrl_n;
  assign bus_rd_no   = strb.rd_n;
  assign bus_ce_no   = ~active;
  assign bus_dq_o    = wdata_q;
  assign bus_dq_oe_o = active & we_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int BADR_W = 23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_bsl_mode_i,
  input logic              req_ready_o,
  input logic [BADR_W-1:0] bus_addr_o,
  input logic              bus_a0_o,
  input logic              bus_ce_no,
  input logic              bus_rd_no,
  input logic              bus_wrh_no,
  input logic              bus_wrl_no,
  input logic              bus_dq_oe_o
);
  a_r10_ready_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);

  a_r10_ready_after_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> $past(!bus_ce_no));

  a_r8_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ce_no && $past(!bus_ce_no)) |-> $stable(bus_addr_o));

  a_r8_strobes_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ce_no && $past(!bus_ce_no)) |-> $stable({bus_a0_o, bus_rd_no, bus_wrh_no, bus_wrl_no}));

  a_r8_idle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (bus_ce_no && bus_rd_no && bus_wrh_no && bus_wrl_no));

  a_r9_oe_in_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dq_oe_o |-> (!bus_ce_no && bus_rd_no));

  a_r5_no_write_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_bsl_mode_i && !bus_rd_no) |-> (bus_wrh_no && bus_wrl_no));
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.BADR_W(BADR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_bsl_mode_i (cfg_bsl_mode_i),
  .req_ready_o    (req_ready_o),
  .bus_addr_o     (bus_addr_o),
  .bus_a0_o       (bus_a0_o),
  .bus_ce_no      (bus_ce_no),
  .bus_rd_no      (bus_rd_no),
  .bus_wrh_no     (bus_wrh_no),
  .bus_wrl_no     (bus_wrl_no),
  .bus_dq_oe_o    (bus_dq_oe_o)
);

// File: tb/tb_sram_bus_ctrl.sv
`timescale 1ns/1ps
module tb_sram_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        is_sram = 1'b1, wait_en = 1'b1, bsl = 1'b0, big = 1'b0;
  logic [2:0]  int_wait = '0;
  logic        valid = 1'b0, we = 1'b0;
  logic [1:0]  be = 2'b11;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ready;
  logic [15:0] rdata;
  logic [22:0] baddr;
  logic        a0, ce_n, rd_n, wrh_n, wrl_n, oe;
  logic [15:0] dq_o, dq_i;
  logic        ext_wait_n = 1'b1;

  int n_chk = 0, n_fail = 0;
  int cur_n = 0, cur_k = 0, acc_cyc = 0;

  always #10 clk = ~clk;

  sram_bus_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_is_sram_i(is_sram), .cfg_wait_en_i(wait_en),
    .cfg_bsl_mode_i(bsl), .cfg_big_endian_i(big), .cfg_int_wait_i(int_wait),
    .req_valid_i(valid), .req_we_i(we), .req_be_i(be), .req_addr_i(addr),
    .req_wdata_i(wdata), .req_ready_o(ready), .rsp_rdata_o(rdata),
    .bus_addr_o(baddr), .bus_a0_o(a0), .bus_ce_no(ce_n), .bus_rd_no(rd_n),
    .bus_wrh_no(wrh_n), .bus_wrl_no(wrl_n), .bus_dq_o(dq_o), .bus_dq_oe_o(oe),
    .bus_dq_i(dq_i), .bus_ext_wait_ni(ext_wait_n)
  );

  // memory model: data only while output enable is low
  assign dq_i = !rd_n ? {baddr[7:0] ^ 8'h5a, ~baddr[7:0]} : 16'h0000;

  // external wait low over access cycles 1..N+K
  always @(posedge clk) begin
    #2;
    if (ce_n) acc_cyc = 0;
    else      acc_cyc = acc_cyc + 1;
    ext_wait_n = !(acc_cyc >= 1 && acc_cyc <= cur_n + cur_k);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
    end
  endtask

  task automatic run_access(input int n, input int k, input bit s, input bit w,
                            input bit wr, input bit m, input bit e,
                            input logic [1:0] b, input logic [23:0] ad,
                            input logic [15:0] wd);
    int len, exp_len;
    bit done, strb_bad, oe_bad, ad_bad;
    logic [3:0] exp_s, first_s;
    logic sl, sh;
    @(negedge clk);
    cur_n = n; cur_k = k;
    is_sram = s; wait_en = w; int_wait = 3'(n);
    bsl = m; big = e; we = wr; be = b; addr = ad; wdata = wd;
    valid = 1'b1;
    exp_len = n + 1 + ((s && w) ? k : 0);
    sl = e ? b[1] : b[0];
    sh = e ? b[0] : b[1];
    if (m) exp_s = {~sl, ~sh, ~wr, wr};
    else   exp_s = {ad[0], ~(wr & b[1]), ~(wr & b[0]), wr};
    len = 0; done = 0; strb_bad = 0; oe_bad = 0; ad_bad = 0; first_s = 4'h0;
    for (int t = 0; t < 64 && !done; t++) begin
      @(negedge clk);
      if (!ce_n) begin
        len++;
        if (len == 1) first_s = {a0, wrh_n, wrl_n, rd_n};
        else if ({a0, wrh_n, wrl_n, rd_n} != exp_s) strb_bad = 1;
        if (baddr != ad[23:1]) ad_bad = 1;
        if (wr ? (!oe || dq_o != wd) : oe) oe_bad = 1;
      end
      if (ready) done = 1;
    end
    if (m && e)  chk(first_s == exp_s, "R7 big-endian byte-select strobes", first_s, exp_s);
    else if (m)  chk(first_s == exp_s, "R6 little-endian byte-select strobes", first_s, exp_s);
    else         chk(first_s == exp_s, "R5 address-bit-zero strobes", first_s, exp_s);
    if (!(s && w))  chk(len == exp_len, "R4 wait pin gated off length", len, exp_len);
    else if (k > 0) chk(len == exp_len, "R3 external wait length", len, exp_len);
    else if (n > 0) chk(len == exp_len, "R2 internal wait length", len, exp_len);
    else            chk(len == exp_len, "R1 no-wait single cycle", len, exp_len);
    chk(!strb_bad && !ad_bad, "R8 strobes and address steady", {strb_bad, ad_bad}, 0);
    chk(!oe_bad, "R9 write data drive", oe_bad, 0);
    chk(done && ce_n && rd_n && wrh_n && wrl_n, "R8 idle during ready", {done, ce_n, rd_n, wrh_n, wrl_n}, 5'h1f);
    if (!wr) chk(rdata == {ad[8:1] ^ 8'h5a, ~ad[8:1]}, "R10 read data",
                 rdata, {ad[8:1] ^ 8'h5a, ~ad[8:1]});
    valid = 1'b0;
    @(negedge clk);
    chk(!ready, "R10 ready single clock", ready, 0);
  endtask

  initial begin
    int idx;
    #35;
    chk(ce_n && rd_n && wrh_n && wrl_n && !ready && !oe, "R11 reset state",
        {ce_n, rd_n, wrh_n, wrl_n, ready, oe}, 6'b111100);
    rst_n = 1'b1;
    idx = 0;
    for (int n = 0; n < 8; n++)
      for (int k = 0; k < 3; k++)
        for (int g = 0; g < 4; g++)
          for (int wr = 0; wr < 2; wr++)
            for (int mm = 0; mm < 4; mm++)
              for (int b = 1; b < 4; b++) begin
                idx++;
                run_access(n, k, g[1], g[0], wr[0], mm[1], mm[0], 2'(b),
                           24'(idx * 24'h000b35), 16'(idx * 16'h3d17 + 16'h0101));
              end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule